// File: doc/BRIEF.md
# Interrupt Controller with Delayed Master Enable

This block sits beside a small processor core and keeps track of which interrupt sources are waiting and which of them the software allows. Five peripheral request lines each set one bit of a pending register. The core writes an enable register with one bit per source. A source can be serviced only when its bit is set in both registers. At each instruction boundary the block decides whether to hand one of those sources to the core.

A three-state master enable governs dispatch. An enable-interrupts pulse does not open the gate at once. The first boundary check after it only arms the gate, so one further instruction always runs before any interrupt is taken. A disable pulse shuts the gate at once. When the gate is open and a source can be serviced at a boundary, the block raises a dispatch request for that cycle and presents a vector for the lowest-numbered source. At the next clock edge it clears that source's pending bit and shuts the gate again. A separate wake output tells a halted core that a serviceable source exists, whatever the state of the gate.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset both registers hold zero in their five low bits, so each reads back as 0xE0. After reset, dispatch and wake are low.
- R2: A high bit on `req_i` sets the matching pending bit at the next clock edge, whatever the enable register holds. The bit stays set until software or a dispatch clears it. The bit positions are: bit 0 frame-blank, bit 1 display status, bit 2 timer, bit 3 serial link, bit 4 keypad.
- R3: With `reg_sel`=0 the register port addresses the pending register, and with `reg_sel`=1 it addresses the enable register. A write replaces bits 4:0 with `reg_wdata[4:0]`. Bits 7:5 always read as 1.
- R4: `wake_o` is high exactly when (pending AND enable AND 0x1F) is nonzero, even when the master enable is off.
- R5: After an enable pulse, the first boundary check dispatches nothing and switches the master enable on. A later boundary check may then dispatch.
- R6: `dispatch_o` is high in a cycle only when `boundary_i` is high, the master enable is already on, and a serviceable source exists. Without a boundary strobe, or with no serviceable source, the master enable stays on.
- R7: When several sources are serviceable, the lowest bit index wins. `vector_o` equals 0x40 + 8 × index (0x40, 0x48, 0x50, 0x58, 0x60).
- R8: At the clock edge that ends a dispatch cycle, the chosen pending bit is cleared and the other bits are kept. The master enable turns off, so the next boundary check dispatches nothing.
- R9: A disable pulse turns the master enable off at the next edge, from either the armed state or the on state.
- R10: A request on the same edge as a clear of the same bit wins, whether the clear comes from a dispatch or from a register write. The bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 5 | Peripheral request pulses, one bit per source |
| reg_sel | input | 1 | Register select: 0 pending, 1 enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, upper bits forced to 1 |
| boundary_i | input | 1 | Instruction-boundary check strobe |
| ei_i | input | 1 | Enable-interrupts pulse |
| di_i | input | 1 | Disable-interrupts pulse |
| dispatch_o | output | 1 | Interrupt taken in this cycle |
| vector_o | output | 8 | Vector of the winning source |
| wake_o | output | 1 | A serviceable source exists |

## Verification
The master enable cannot be seen at the ports. Its armed state shows only as a boundary check that does not dispatch even though a serviceable source is waiting. The bench therefore loads both registers first, then issues an enable pulse, and then checks two boundary strobes in a row. The first must stay quiet and the second must fire. The same sequence with a disable pulse inserted shows that the armed state can be cancelled. A boundary check made while nothing is serviceable shows that the on state survives that check.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared types for the interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_ctrl_pkg;

    // Master enable states: closed, armed by an enable pulse, open
    typedef enum logic [1:0] {
        MEN_OFF   = 2'd0,
        MEN_ARMED = 2'd1,
        MEN_ON    = 2'd2
    } men_state_e;

endpackage

// File: rtl/irq_reg_bank.sv
// Module: pending and enable registers of the interrupt controller.
// What it does: holds one pending bit and one enable bit per source.
// Software may replace either register through the write port.
// Assumes: requests, software writes and dispatch clears can all hit a
// pending bit in the same cycle. A request has the highest priority.
module irq_reg_bank #(
    parameter int N_SRC  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  req_i,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_SRC-1:0]  clr_mask,
    output logic [N_SRC-1:0]  pend_q,
    output logic [N_SRC-1:0]  en_q
);

    logic pend_wr;
    logic en_wr;

    // Decode which register the port write addresses
    always_comb begin
        pend_wr = wr_en && !wr_sel;
        en_wr   = wr_en &&  wr_sel;
    end

    genvar b;
    generate
        for (b = 0; b < N_SRC; b++) begin : g_bit
            logic base_pend;

            // Pending bit before the request is merged: written value or held value, minus a dispatch clear
            always_comb begin
                base_pend = pend_wr ? wr_data[b] : pend_q[b];
                if (clr_mask[b]) begin
                    base_pend = 1'b0;
                end
            end

            // Pending bit register; a request always sets it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[b] <= 1'b0;
                end else begin
                    pend_q[b] <= base_pend | req_i[b];
                end
            end

            // Enable bit register, written only by software
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q[b] <= 1'b0;
                end else if (en_wr) begin
                    en_q[b] <= wr_data[b];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority picker and vector generator.
// What it does: finds the lowest set bit of the serviceable set and
// returns it one-hot, together with its vector BASE + STEP*index.
// Assumes: the vector arithmetic fits in DATA_W bits.
module irq_prio_pick #(
    parameter int N_SRC    = 5,
    parameter int DATA_W   = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_STEP = 8
) (
    input  logic [N_SRC-1:0]  svc_i,
    output logic              any_o,
    output logic [N_SRC-1:0]  win_o,
    output logic [DATA_W-1:0] vector_o
);

    // Scan from the top down so that the lowest set index is kept last
    always_comb begin
        any_o    = 1'b0;
        win_o    = '0;
        vector_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (svc_i[i]) begin
                any_o    = 1'b1;
                win_o    = '0;
                win_o[i] = 1'b1;
                vector_o = DATA_W'(VEC_BASE + i * VEC_STEP);
            end
        end
    end

endmodule

// File: rtl/irq_master_en.sv
// Module: three-state master enable with delayed switch-on.
// What it does: an enable pulse arms the gate, and the next boundary
// check opens it without dispatching. A disable pulse or a dispatch
// closes the gate.
// Assumes: the pulses are one cycle wide. Disable has the highest priority.
module irq_master_en
    import irq_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ei_i,
    input  logic       di_i,
    input  logic       boundary_i,
    input  logic       svc_any_i,
    output men_state_e state_q,
    output logic       dispatch_o
);

    men_state_e state_d;

    // Dispatch only at a boundary while the gate is already open
    always_comb begin
        dispatch_o = boundary_i && (state_q == MEN_ON) && svc_any_i;
    end

    // Next-state selection of the master enable
    always_comb begin
        state_d = state_q;
        if (di_i || dispatch_o) begin
            state_d = MEN_OFF;
        end else begin
            case (state_q)
                MEN_OFF:   if (ei_i)       state_d = MEN_ARMED;
                MEN_ARMED: if (boundary_i) state_d = MEN_ON;
                MEN_ON:                    state_d = MEN_ON;
                default:                   state_d = MEN_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MEN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/irq_dispatch_ctrl.sv
// Module: top of the interrupt controller.
// What it does: joins the registers, the priority picker and the master
// enable. It forms the serviceable set, the wake output and the read-back path.
// Assumes: N_SRC < DATA_W. Unused upper register bits read as 1.
module irq_dispatch_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N_SRC    = 5,
    parameter int DATA_W   = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  req_i,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              boundary_i,
    input  logic              ei_i,
    input  logic              di_i,
    output logic              dispatch_o,
    output logic [DATA_W-1:0] vector_o,
    output logic              wake_o
);

    localparam int PAD_W = DATA_W - N_SRC;

    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] svc;
    logic [N_SRC-1:0] win;
    logic [N_SRC-1:0] clr_mask;
    logic             svc_any;
    men_state_e       men_state;

    irq_reg_bank #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .wr_en    (reg_wr),
        .wr_sel   (reg_sel),
        .wr_data  (reg_wdata),
        .clr_mask (clr_mask),
        .pend_q   (pend_q),
        .en_q     (en_q)
    );

    // Serviceable set: pending and enabled
    always_comb begin
        svc = pend_q & en_q;
    end

    irq_prio_pick #(
        .N_SRC(N_SRC), .DATA_W(DATA_W),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_pick (
        .svc_i    (svc),
        .any_o    (svc_any),
        .win_o    (win),
        .vector_o (vector_o)
    );

    irq_master_en u_men (
        .clk        (clk),
        .rst_n      (rst_n),
        .ei_i       (ei_i),
        .di_i       (di_i),
        .boundary_i (boundary_i),
        .svc_any_i  (svc_any),
        .state_q    (men_state),
        .dispatch_o (dispatch_o)
    );

    // Clear the winning pending bit only in a dispatch cycle
    always_comb begin
        clr_mask = dispatch_o ? win : '0;
    end

    // Wake a halted core whenever something is serviceable
    always_comb begin
        wake_o = svc_any;
    end

    // Read-back of the selected register with the upper bits padded with ones
    always_comb begin
        reg_rdata = reg_sel ? {{PAD_W{1'b1}}, en_q} : {{PAD_W{1'b1}}, pend_q};
    end

endmodule

// File: rtl/irq_dispatch_chk.sv
// Module: property checker for the interrupt controller, attached by bind.
// Assumes: it is bound inside irq_dispatch_ctrl, where men_state is visible.
module irq_dispatch_chk
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary_i,
    input logic              di_i,
    input logic              dispatch_o,
    input logic              wake_o,
    input logic [DATA_W-1:0] vector_o,
    input logic [1:0]        men_state
);

    // R6
    dispatch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |-> (boundary_i && wake_o));

    // R5
    arm_to_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(men_state == MEN_ON) |-> $past(boundary_i));

    // R7
    vector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |-> (vector_o[2:0] == 3'b000 && vector_o >= DATA_W'(64) && vector_o <= DATA_W'(96)));

    // R8
    single_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |=> !dispatch_o);

    // R9
    disable_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> (men_state == MEN_OFF));

endmodule

bind irq_dispatch_ctrl irq_dispatch_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .di_i       (di_i),
    .dispatch_o (dispatch_o),
    .wake_o     (wake_o),
    .vector_o   (vector_o),
    .men_state  (men_state)
);

// File: tb/test_irq_dispatch_ctrl.sv
`timescale 1ns/1ps
module test_irq_dispatch_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req_i = '0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       boundary_i = 1'b0;
    logic       ei_i = 1'b0;
    logic       di_i = 1'b0;
    logic       dispatch_o;
    logic [7:0] vector_o;
    logic       wake_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irq_dispatch_ctrl i_irq_dispatch_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .boundary_i(boundary_i), .ei_i(ei_i), .di_i(di_i),
        .dispatch_o(dispatch_o), .vector_o(vector_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] val);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic read_check(input logic sel, input logic [7:0] exp, input string req);
        reg_sel = sel;
        #1;
        check(req, reg_rdata, exp);
        step();
    endtask

    task automatic pulse_req(input logic [4:0] m);
        req_i = m; step(); req_i = '0;
    endtask

    task automatic pulse_ei();
        ei_i = 1'b1; step(); ei_i = 1'b0;
    endtask

    task automatic pulse_di();
        di_i = 1'b1; step(); di_i = 1'b0;
    endtask

    // Boundary strobe; checks dispatch and, if expected, the vector
    task automatic boundary(input logic exp_d, input logic [7:0] exp_v, input string req);
        boundary_i = 1'b1;
        #1;
        check(req, {7'd0, dispatch_o}, {7'd0, exp_d});
        if (exp_d) check(req, vector_o, exp_v);
        step();
        boundary_i = 1'b0;
    endtask

    task automatic clear_all();
        pulse_di();
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'h00);
    endtask

    task automatic t_reset();
        check("R1 wake", {7'd0, wake_o}, 8'h00);
        check("R1 dispatch", {7'd0, dispatch_o}, 8'h00);
        read_check(1'b0, 8'hE0, "R1 pending");
        read_check(1'b1, 8'hE0, "R1 enable");
    endtask

    task automatic t_regport();
        write_reg(1'b0, 8'hFF);
        read_check(1'b0, 8'hFF, "R3 pending all");
        write_reg(1'b1, 8'h15);
        read_check(1'b1, 8'hF5, "R3 enable 0x15");
        write_reg(1'b0, 8'h0A);
        read_check(1'b0, 8'hEA, "R3 pending 0x0A upper ones");
        clear_all();
    endtask

    task automatic t_request();
        pulse_req(5'h04);
        read_check(1'b0, 8'hE4, "R2 timer bit set");
        check("R4 wake masked off", {7'd0, wake_o}, 8'h00);
        pulse_req(5'h10);
        read_check(1'b0, 8'hF4, "R2 keypad bit added");
        write_reg(1'b1, 8'h04);
        check("R4 wake with master off", {7'd0, wake_o}, 8'h01);
        boundary(1'b0, 8'h00, "R6 no dispatch while off");
        read_check(1'b0, 8'hF4, "R2 bits held");
        clear_all();
    endtask

    task automatic t_ei_delay();
        pulse_req(5'h08);
        write_reg(1'b1, 8'h1F);
        pulse_ei();
        boundary(1'b0, 8'h00, "R5 first boundary after enable");
        boundary(1'b1, 8'h58, "R5 second boundary dispatch serial");
        read_check(1'b0, 8'hE0, "R8 serial bit cleared");
        check("R4 wake after clear", {7'd0, wake_o}, 8'h00);
        clear_all();
    endtask

    task automatic t_priority();
        pulse_req(5'h1A);
        write_reg(1'b1, 8'h1F);
        pulse_ei();
        boundary(1'b0, 8'h00, "R5 armed");
        boundary(1'b1, 8'h48, "R7 lowest wins status");
        read_check(1'b0, 8'hF8, "R8 only winner cleared");
        boundary(1'b0, 8'h00, "R8 master off after dispatch");
        pulse_ei();
        boundary(1'b0, 8'h00, "R5 armed again");
        boundary(1'b1, 8'h58, "R7 serial next");
        pulse_ei();
        boundary(1'b0, 8'h00, "R5 armed third");
        boundary(1'b1, 8'h60, "R7 keypad last");
        read_check(1'b0, 8'hE0, "R8 all cleared");
        clear_all();
    endtask

    task automatic t_masked();
        pulse_req(5'h01);
        write_reg(1'b1, 8'h10);
        pulse_ei();
        boundary(1'b0, 8'h00, "R5 armed");
        boundary(1'b0, 8'h00, "R6 nothing serviceable");
        pulse_req(5'h10);
        #1;
        check("R6 no boundary no dispatch", {7'd0, dispatch_o}, 8'h00);
        step();
        boundary(1'b1, 8'h60, "R6 master stayed on");
        read_check(1'b0, 8'hE1, "R8 masked bit kept");
        clear_all();
    endtask

    task automatic t_disable();
        pulse_req(5'h04);
        write_reg(1'b1, 8'h04);
        pulse_ei();
        pulse_di();
        boundary(1'b0, 8'h00, "R9 armed cancelled");
        boundary(1'b0, 8'h00, "R9 still off");
        pulse_ei();
        boundary(1'b0, 8'h00, "R5 armed");
        pulse_di();
        boundary(1'b0, 8'h00, "R9 on closed");
        read_check(1'b0, 8'hE4, "R9 bit still pending");
        clear_all();
    endtask

    task automatic t_race();
        pulse_req(5'h01);
        write_reg(1'b1, 8'h01);
        pulse_ei();
        boundary(1'b0, 8'h00, "R5 armed");
        req_i = 5'h01;
        boundary(1'b1, 8'h40, "R10 dispatch frame-blank");
        req_i = '0;
        read_check(1'b0, 8'hE1, "R10 request beats dispatch clear");
        req_i = 5'h02;
        write_reg(1'b0, 8'h00);
        req_i = '0;
        read_check(1'b0, 8'hE2, "R10 request beats write");
        clear_all();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_regport();
        t_request();
        t_ei_delay();
        t_priority();
        t_masked();
        t_disable();
        t_race();
        summary();
        $finish;
    end

endmodule